// File: doc/BRIEF.md
# Register-Saving Interrupt Entry and Return Unit

This block owns the program counter, the machine state word and two save registers of a processor that keeps interrupt context in registers rather than on a memory stack. When an interrupt is accepted, the unit copies the return address into the first save register and the pre-entry state word, tagged with a cause code, into the second. In the same step it replaces the state word with a fixed handler image and points the program counter at the handler for that interrupt type. A return instruction copies both save registers back into the live registers.

Interrupt sources are four fault request lines, an external interrupt line, and two trace sources that come from the instruction-retired and branch-retired pulses. A fixed priority picks one source per cycle. The external line is gated by an enable bit in the state word, and each trace source is gated by its own state bit. A return attempted from user mode becomes a program interrupt. When no interrupt and no return happens, the program counter follows the next address supplied by the core, and the core can write the state word directly.

Top module: `srr_irq_unit`

## Requirements
- R1: After reset the program counter equals RESET_PC (default 0x100), and the state word and both save registers are zero.
- R2: On entry, save register 0 receives the current program counter for faults and program interrupts. For external and trace interrupts it receives the core's next address when core_pc_vld is high, and the current program counter otherwise.
- R3: On entry, save register 1 receives the pre-entry state word with bits 35:32 replaced by the type number of the interrupt taken.
- R4: On entry, the state word keeps only bit 57 (vector base select) and bit 63 (endianness) of its old value. Every other bit becomes 0. This turns off external enable (48), user mode (49), both trace enables (53, 54) and both address translation bits (58, 59).
- R5: The handler address is the base plus the type number times 0x100. The base is 0xFFFF_FFFF_FFF0_0000 when state bit 57 is set and zero otherwise. The type numbers are: machine check 2, data fault 3, instruction fault 4, external 5, alignment 6, program 7, trace 13.
- R6: When several sources are active, the unit takes exactly one, in this order: machine check, program (user-mode return), data fault, instruction fault, alignment, external, trace. fault_req bit 0 is machine check, bit 1 is data fault, bit 2 is instruction fault, and bit 3 is alignment.
- R7: ext_irq is ignored while state bit 48 is 0.
- R8: A trace interrupt is raised by instr_done while state bit 53 is 1, or by branch_done while state bit 54 is 1. With the matching bit clear, the pulse has no effect.
- R9: A return in privileged mode (bit 49 = 0) with no fault active loads the program counter from save register 0 and the state word from save register 1. The save registers are left unchanged, and ext_irq and trace pulses are not taken in that cycle.
- R10: A return in user mode (bit 49 = 1) does not execute. It raises a program interrupt (type 7) with save register 0 equal to the return's own program counter.
- R11: With no interrupt and no return, the program counter loads core_pc when core_pc_vld is high and holds otherwise, and msr_wr loads the state word with msr_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_pc_vld | input | 1 | core_pc holds the next program counter |
| core_pc | input | 64 | Next address from the core |
| msr_wr | input | 1 | Write the state word |
| msr_wdata | input | 64 | State word write data |
| fault_req | input | 4 | Fault requests: 0 machine check, 1 data, 2 instruction, 3 alignment |
| ext_irq | input | 1 | External interrupt request |
| instr_done | input | 1 | One instruction retired |
| branch_done | input | 1 | One taken branch retired |
| rfi | input | 1 | Return-from-interrupt strobe |
| pc_o | output | 64 | Program counter |
| msr_o | output | 64 | Machine state word |
| srr0_o | output | 64 | Save register 0 (return address) |
| srr1_o | output | 64 | Save register 1 (saved state and cause) |

## Verification
The bench stacks every source in one cycle and then removes the winner one step at a time. A wrong priority chain would jump to the wrong offset and leave the wrong cause code in save register 1. It raises the external line while its enable bit is clear, and it sends each trace pulse while only the other trace bit is set; a missing mask would take an interrupt where the program counter should just follow the core. It checks that faults save the current address while asynchronous sources save the core's next address, so a swap shows up as an off-by-one-instruction return address. It also fires a return from user mode together with a fault and with the external line, and fires a privileged return together with a fault. A design that executed those returns, or ranked them wrongly, would restore the save registers instead of entering the handler.

// File: rtl/srr_pkg.sv
package srr_pkg;
    // state word bit positions (behaviour depends on them)
    localparam int MSR_EE = 48;   // external interrupt enable
    localparam int MSR_PR = 49;   // user (unprivileged) mode
    localparam int MSR_SE = 53;   // trace every instruction
    localparam int MSR_BE = 54;   // trace every taken branch
    localparam int MSR_IP = 57;   // vector base select
    localparam int MSR_IR = 58;   // instruction translation
    localparam int MSR_DR = 59;   // data translation
    localparam int MSR_LE = 63;   // endianness

    // cause field written into save register 1
    localparam int CAUSE_LSB = 32;
    localparam int CAUSE_W   = 4;

    // number of prioritised sources
    localparam int NSRC = 7;

    typedef enum logic [CAUSE_W-1:0] {
        T_NONE  = 4'd0,
        T_MCHK  = 4'd2,
        T_DSI   = 4'd3,
        T_ISI   = 4'd4,
        T_EXT   = 4'd5,
        T_ALIGN = 4'd6,
        T_PROG  = 4'd7,
        T_TRACE = 4'd13
    } itype_e;

    typedef struct packed {
        logic [63:0] pc;
        logic [63:0] msr;
        logic [63:0] srr0;
        logic [63:0] srr1;
    } ctx_t;
endpackage

// File: rtl/srr_prio.sv
module srr_prio
    import srr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] fault_req,
    input  logic       rfi,
    input  logic       user_mode,
    input  logic       ext_irq,
    input  logic       ext_en,
    input  logic       instr_done,
    input  logic       branch_done,
    input  logic       trace_ins_en,
    input  logic       trace_br_en,
    output logic       take,
    output itype_e     sel,
    output logic       save_next,
    output logic       rfi_exec
);
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] grant;

    function automatic itype_e src_type(input int idx);
        case (idx)
            0:       return T_MCHK;
            1:       return T_PROG;
            2:       return T_DSI;
            3:       return T_ISI;
            4:       return T_ALIGN;
            5:       return T_EXT;
            default: return T_TRACE;
        endcase
    endfunction

    // request vector in priority order, index 0 highest
    always_comb begin
        raw[0] = fault_req[0];
        raw[1] = rfi & user_mode;
        raw[2] = fault_req[1];
        raw[3] = fault_req[2];
        raw[4] = fault_req[3];
        raw[5] = ext_irq & ext_en & ~rfi;
        raw[6] = ((instr_done & trace_ins_en) | (branch_done & trace_br_en)) & ~rfi;
    end

    always_comb begin
        logic found;
        found = 1'b0;
        sel   = T_NONE;
        for (int i = 0; i < NSRC; i++) begin
            grant[i] = raw[i] & ~found;
            if (grant[i]) sel = src_type(i);
            found = found | raw[i];
        end
    end

    assign take      = |raw;
    assign save_next = grant[5] | grant[6];
    assign rfi_exec  = rfi & ~user_mode & ~(|raw[4:0]);

    assert_ext_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |-> sel != T_EXT);
    assert_trace_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(trace_ins_en | trace_br_en) |-> sel != T_TRACE);
    assert_rfi_not_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rfi_exec |-> !take);
    assert_mchk_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req[0] |-> sel == T_MCHK);
endmodule

// File: rtl/srr_vector.sv
module srr_vector
    import srr_pkg::*;
#(
    parameter int XLEN          = 64,
    parameter int VEC_SHIFT     = 8,
    parameter int BASE_LOW_BITS = 20
) (
    input  logic               hi_base,
    input  logic [CAUSE_W-1:0] itype,
    output logic [XLEN-1:0]    handler
);
    localparam logic [XLEN-1:0] HIGH_BASE = {XLEN{1'b1}} << BASE_LOW_BITS;

    logic [XLEN-1:0] offset;
    assign offset  = XLEN'(itype) << VEC_SHIFT;
    assign handler = (hi_base ? HIGH_BASE : '0) + offset;
endmodule

// File: rtl/srr_image.sv
module srr_image
    import srr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]    msr_i,
    input  logic [CAUSE_W-1:0] cause_i,
    output logic [XLEN-1:0]    entry_msr,
    output logic [XLEN-1:0]    srr1_img
);
    for (genvar b = 0; b < XLEN; b++) begin : g_bit
        if (b == MSR_IP || b == MSR_LE) begin : g_keep
            assign entry_msr[b] = msr_i[b];
        end else begin : g_clr
            assign entry_msr[b] = 1'b0;
        end
        if (b >= CAUSE_LSB && b < CAUSE_LSB + CAUSE_W) begin : g_cause
            assign srr1_img[b] = cause_i[b - CAUSE_LSB];
        end else begin : g_copy
            assign srr1_img[b] = msr_i[b];
        end
    end
endmodule

// File: rtl/srr_irq_unit.sv
module srr_irq_unit
    import srr_pkg::*;
#(
    parameter int          XLEN          = 64,   // at least 64: state bits reach 63
    parameter logic [63:0] RESET_PC      = 64'h100,
    parameter int          VEC_SHIFT     = 8,
    parameter int          BASE_LOW_BITS = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            core_pc_vld,
    input  logic [XLEN-1:0] core_pc,
    input  logic            msr_wr,
    input  logic [XLEN-1:0] msr_wdata,
    input  logic [3:0]      fault_req,
    input  logic            ext_irq,
    input  logic            instr_done,
    input  logic            branch_done,
    input  logic            rfi,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] msr_o,
    output logic [XLEN-1:0] srr0_o,
    output logic [XLEN-1:0] srr1_o
);
    ctx_t st_d, st_q;

    logic        take, save_next, rfi_exec;
    itype_e      sel;
    logic [63:0] handler, entry_msr, srr1_img;

    srr_prio u_prio (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_req    (fault_req),
        .rfi          (rfi),
        .user_mode    (st_q.msr[MSR_PR]),
        .ext_irq      (ext_irq),
        .ext_en       (st_q.msr[MSR_EE]),
        .instr_done   (instr_done),
        .branch_done  (branch_done),
        .trace_ins_en (st_q.msr[MSR_SE]),
        .trace_br_en  (st_q.msr[MSR_BE]),
        .take         (take),
        .sel          (sel),
        .save_next    (save_next),
        .rfi_exec     (rfi_exec)
    );

    srr_vector #(
        .XLEN          (64),
        .VEC_SHIFT     (VEC_SHIFT),
        .BASE_LOW_BITS (BASE_LOW_BITS)
    ) u_vector (
        .hi_base (st_q.msr[MSR_IP]),
        .itype   (sel),
        .handler (handler)
    );

    srr_image #(.XLEN(64)) u_image (
        .msr_i     (st_q.msr),
        .cause_i   (sel),
        .entry_msr (entry_msr),
        .srr1_img  (srr1_img)
    );

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.pc   = handler;
            st_d.msr  = entry_msr;
            st_d.srr0 = (save_next && core_pc_vld) ? 64'(core_pc) : st_q.pc;
            st_d.srr1 = srr1_img;
        end else if (rfi_exec) begin
            st_d.pc  = st_q.srr0;
            st_d.msr = st_q.srr1;
        end else begin
            if (core_pc_vld) st_d.pc  = 64'(core_pc);
            if (msr_wr)      st_d.msr = 64'(msr_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.pc   <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o   = XLEN'(st_q.pc);
    assign msr_o  = XLEN'(st_q.msr);
    assign srr0_o = XLEN'(st_q.srr0);
    assign srr1_o = XLEN'(st_q.srr1);

    assert_entry_image_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !st_q.msr[MSR_EE] && !st_q.msr[MSR_PR] && !st_q.msr[MSR_SE]
              && !st_q.msr[MSR_BE] && !st_q.msr[MSR_IR] && !st_q.msr[MSR_DR]);
    assert_fault_save_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !save_next) |=> st_q.srr0 == $past(st_q.pc));
    assert_vec_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> st_q.pc[VEC_SHIFT-1:0] == '0);
    assert_rfi_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rfi_exec |=> st_q.pc == $past(st_q.srr0) && st_q.msr == $past(st_q.srr1));
    assert_user_rfi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rfi && st_q.msr[MSR_PR] && !fault_req[0]) |=>
            st_q.srr1[CAUSE_LSB +: CAUSE_W] == 4'd7);
endmodule

// File: tb/test_srr_irq_unit.sv
module test_srr_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_pc_vld = 1'b0;
    logic [63:0] core_pc = '0;
    logic        msr_wr = 1'b0;
    logic [63:0] msr_wdata = '0;
    logic [3:0]  fault_req = '0;
    logic        ext_irq = 1'b0, instr_done = 1'b0, branch_done = 1'b0, rfi = 1'b0;
    logic [63:0] pc_o, msr_o, srr0_o, srr1_o;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [63:0] HB = 64'hFFFF_FFFF_FFF0_0000;
    localparam logic [63:0] B_EE = 64'd1 << 48, B_PR = 64'd1 << 49, B_SE = 64'd1 << 53;
    localparam logic [63:0] B_BE = 64'd1 << 54, B_IP = 64'd1 << 57, B_IR = 64'd1 << 58;
    localparam logic [63:0] B_DR = 64'd1 << 59, B_LE = 64'd1 << 63;

    always #10 clk = ~clk;

    srr_irq_unit i_srr_irq_unit (
        .clk, .rst_n, .core_pc_vld, .core_pc, .msr_wr, .msr_wdata, .fault_req,
        .ext_irq, .instr_done, .branch_done, .rfi, .pc_o, .msr_o, .srr0_o, .srr1_o
    );

    function automatic logic [63:0] vec(input logic [63:0] m, input int t);
        return (m[57] ? HB : 64'd0) + 64'(t) * 64'h100;
    endfunction
    function automatic logic [63:0] img(input logic [63:0] m);
        return m & (B_IP | B_LE);
    endfunction
    function automatic logic [63:0] s1(input logic [63:0] m, input int t);
        logic [63:0] r;
        r = m;
        r[35:32] = 4'(t);
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one cycle: inputs already driven at a falling edge; sample at the next falling edge
    task automatic tick();
        @(negedge clk);
        core_pc_vld = 0; msr_wr = 0; fault_req = 0;
        ext_irq = 0; instr_done = 0; branch_done = 0; rfi = 0;
    endtask

    task automatic set_ctx(input logic [63:0] p, input logic [63:0] m);
        core_pc_vld = 1; core_pc = p; msr_wr = 1; msr_wdata = m;
        tick();
    endtask

    task automatic t_reset();
        chk("R1", "pc", pc_o, 64'h100);
        chk("R1", "msr", msr_o, 64'd0);
        chk("R1", "srr0", srr0_o, 64'd0);
        chk("R1", "srr1", srr1_o, 64'd0);
    endtask

    task automatic t_normal();
        logic [63:0] m;
        m = B_LE | B_DR | B_IR | B_PR | 64'd1;
        core_pc_vld = 1; core_pc = 64'h2000; tick();
        chk("R11", "pc follows core", pc_o, 64'h2000);
        tick();
        chk("R11", "pc holds", pc_o, 64'h2000);
        msr_wr = 1; msr_wdata = m; tick();
        chk("R11", "msr write", msr_o, m);
    endtask

    task automatic t_ext_rfi();
        logic [63:0] m, me, s;
        m  = B_LE | B_DR | B_IR | B_PR | 64'd1;
        me = m | B_EE;
        // external masked
        ext_irq = 1; core_pc_vld = 1; core_pc = 64'h3000; tick();
        chk("R7", "masked ext pc", pc_o, 64'h3000);
        chk("R7", "masked ext srr0", srr0_o, 64'd0);
        chk("R7", "masked ext msr", msr_o, m);
        msr_wr = 1; msr_wdata = me; tick();
        // external taken
        ext_irq = 1; core_pc_vld = 1; core_pc = 64'h3004; tick();
        chk("R2", "ext srr0 next addr", srr0_o, 64'h3004);
        chk("R3", "ext srr1", srr1_o, s1(me, 5));
        chk("R4", "ext msr image", msr_o, img(me));
        chk("R5", "ext handler", pc_o, vec(me, 5));
        // privileged return
        s = s1(me, 5);
        rfi = 1; ext_irq = 1; tick();
        chk("R9", "rfi pc", pc_o, 64'h3004);
        chk("R9", "rfi msr", msr_o, s);
        chk("R9", "rfi srr0 kept", srr0_o, 64'h3004);
        chk("R9", "rfi srr1 kept", srr1_o, s);
        // user-mode return with external pending
        rfi = 1; ext_irq = 1; core_pc_vld = 1; core_pc = 64'h3008; tick();
        chk("R10", "user rfi handler", pc_o, vec(s, 7));
        chk("R10", "user rfi srr0", srr0_o, 64'h3004);
        chk("R10", "user rfi srr1", srr1_o, s1(s, 7));
        chk("R10", "user rfi msr", msr_o, img(s));
    endtask

    task automatic t_prio();
        logic [63:0] mp;
        mp = B_IP | B_EE | B_SE;
        set_ctx(64'h5000, mp);
        fault_req = 4'hF; ext_irq = 1; instr_done = 1; core_pc_vld = 1; core_pc = 64'h5004;
        tick();
        chk("R6", "mchk first", pc_o, HB + 64'h200);
        chk("R2", "mchk saves current pc", srr0_o, 64'h5000);
        chk("R4", "mchk msr keeps base bit", msr_o, B_IP);
        chk("R3", "mchk cause", srr1_o, s1(mp, 2));
        set_ctx(64'h5100, mp);
        fault_req = 4'b1110; ext_irq = 1; instr_done = 1; tick();
        chk("R6", "data fault over rest", pc_o, HB + 64'h300);
        chk("R2", "data fault srr0", srr0_o, 64'h5100);
        set_ctx(64'h5200, mp);
        fault_req = 4'b1100; ext_irq = 1; tick();
        chk("R6", "instr fault over align", pc_o, HB + 64'h400);
        set_ctx(64'h5280, mp);
        fault_req = 4'b1000; ext_irq = 1; instr_done = 1; tick();
        chk("R6", "align over ext", pc_o, HB + 64'h600);
        set_ctx(64'h5300, mp | B_PR);
        rfi = 1; fault_req = 4'b0010; tick();
        chk("R6", "program over data fault", pc_o, HB + 64'h700);
        chk("R10", "program srr0", srr0_o, 64'h5300);
        set_ctx(64'h5400, mp);
        rfi = 1; fault_req = 4'b0010; tick();
        chk("R9", "fault blocks privileged rfi", pc_o, HB + 64'h300);
        chk("R9", "fault blocks rfi srr0", srr0_o, 64'h5400);
        chk("R4", "fault blocks rfi msr", msr_o, B_IP);
    endtask

    task automatic t_trace();
        logic [63:0] prev;
        set_ctx(64'h6000, B_SE);
        prev = srr0_o;
        branch_done = 1; core_pc_vld = 1; core_pc = 64'h6010; tick();
        chk("R8", "branch ignored under step", pc_o, 64'h6010);
        chk("R8", "branch ignored srr0", srr0_o, prev);
        instr_done = 1; core_pc_vld = 1; core_pc = 64'h6014; tick();
        chk("R8", "step trace handler", pc_o, 64'hD00);
        chk("R2", "trace saves next", srr0_o, 64'h6014);
        chk("R3", "trace cause", srr1_o, s1(B_SE, 13));
        set_ctx(64'h7000, B_BE);
        prev = srr0_o;
        instr_done = 1; core_pc_vld = 1; core_pc = 64'h7004; tick();
        chk("R8", "instr ignored under branch trace", pc_o, 64'h7004);
        chk("R8", "instr ignored srr0", srr0_o, prev);
        branch_done = 1; core_pc_vld = 1; core_pc = 64'h7100; tick();
        chk("R8", "branch trace handler", pc_o, 64'hD00);
        chk("R8", "branch trace srr0", srr0_o, 64'h7100);
        set_ctx(64'h8000, B_EE | B_SE);
        ext_irq = 1; instr_done = 1; tick();
        chk("R6", "ext over trace", pc_o, 64'h500);
        chk("R2", "ext without next addr", srr0_o, 64'h8000);
        chk("R3", "ext cause", srr1_o, s1(B_EE | B_SE, 5));
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_normal();
        t_ext_rfi();
        t_prio();
        t_trace();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule